// File: doc/BRIEF.md
# Video raster timing generator

This block turns a free-running counter clock enable (one pulse per 2 MHz step) into the raster timing of a video display. A 7-bit horizontal position counter counts upward. When it reaches all ones it reloads with a start value picked by a 2-bit refresh-mode input. Each mode therefore gives its own line length without a terminal-count comparator. One counter step is worth four CPU-clock units.

The reload event is brought out as a line-end strobe. The same event advances a vertical line counter, which wraps to a mode-dependent start value at the end of each frame. Vertical sync is raised over the last lines of the frame: three lines for colour timing and one line when the monochrome flag is in force. Horizontal sync and horizontal blank are decoded from the horizontal position. In monochrome operation blank is held high for the whole line. Mode and the monochrome flag are captured only at a line reload, so a change made in the middle of a line first shows on the following line. The raw counter values are output so that downstream fetch logic can use them.

Top module: `raster_timing_gen`

## Requirements
- R1: While the active-low asynchronous reset is low, the horizontal count is 0, the vertical count is the 50 Hz frame start value (parameter, default 199), the captured line mode is 50 Hz (mode 01) with monochrome off, and vsync, hsync and hblank are all low.
- R2: On each clock with the enable high, the horizontal count goes up by one if it is below 127. With the enable low, both counts hold.
- R3: With the enable high and the horizontal count at 127, the next count is the reload value for the mode input at that edge: 00 gives 1, 01 gives 0, 10 and 11 give 72. The count therefore runs 126, 127, reload value.
- R4: Line length in counter steps is 127 for mode 00 (508 CPU cycles), 128 for mode 01 (512 CPU cycles) and 56 for modes 10 and 11 (224 CPU cycles).
- R5: The line-end strobe is high exactly in cycles where the enable is high and the horizontal count is 127. The vertical count changes only across such a cycle. The line-start strobe is high when the enable is high and the horizontal count equals the reload value of the captured line mode.
- R6: Mode and the monochrome flag are captured only at a line reload. A change made during a line leaves hblank and the current line's count sequence unchanged until the next reload.
- R7: The vertical count climbs to 511 and, at the line end that finds it there, reloads with the start value for the mode input: 00 gives the 60 Hz start (default 249, 263 lines), 01 gives the 50 Hz start (default 199, 313 lines), 10 and 11 give the 70 Hz start (default 11, 501 lines). A frame is 512 minus the start value lines long.
- R8: vsync is high while the vertical count is 509, 510 or 511 with monochrome not captured (3 lines), and only at 511 with monochrome captured (1 line).
- R9: With monochrome not captured, hblank is high exactly when the horizontal count is 112 or more. With monochrome captured, hblank is high in every cycle.
- R10: hsync is high exactly when the horizontal count is 120 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_ce | input | 1 | Counter step enable (2 MHz rate) |
| mode | input | 2 | Refresh mode: 00 60 Hz, 01 50 Hz, 1x 70 Hz |
| mono | input | 1 | Monochrome flag |
| line_end | output | 1 | Strobe on the step at which the line reloads |
| line_start | output | 1 | Strobe on the first step of a line |
| hsync | output | 1 | Horizontal sync |
| hblank | output | 1 | Horizontal blank |
| vsync | output | 1 | Vertical sync |
| hcnt | output | 7 | Raw horizontal count |
| vcnt | output | 9 | Raw vertical count |

## Verification
On every cycle the assertions check the single-step advance of the horizontal count, its hold with the enable low, the legal reload targets after 127, and that the vertical count moves only across a line end. They also check that vsync never appears outside the last three lines and that hblank can only fall at a line reload. Line and frame lengths per mode, the number of sync lines, the deferred effect of a mid-line mode or monochrome change, and the reset values are shown only by the bench's scenarios. The bench uses shortened frames set through parameters.

// File: rtl/raster_pkg.sv
package raster_pkg;

   localparam int unsigned LINE_W = 7;

   typedef enum logic [1:0] {
      RM_60HZ  = 2'b00,
      RM_50HZ  = 2'b01,
      RM_70HZA = 2'b10,
      RM_70HZB = 2'b11
   } rmode_e;

   // Horizontal start value per refresh mode: the line runs from here to all ones.
   function automatic logic [LINE_W-1:0] line_reload(input logic [1:0] m);
      logic [LINE_W-1:0] r;
      unique case (m)
         RM_60HZ:  r = LINE_W'(8'h01);
         RM_50HZ:  r = LINE_W'(8'h00);
         default:  r = LINE_W'(8'h48);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount
   import raster_pkg::*;
#(
   parameter int unsigned HW = LINE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce,
   input  logic [1:0]    mode_in,
   input  logic          mono_in,
   output logic [HW-1:0] hcnt,
   output logic          mono_q,
   output logic          line_end,
   output logic          line_start
);
   localparam logic [HW-1:0] HMAX = {HW{1'b1}};

   logic [1:0] line_mode;
   logic       at_top;

   assign at_top   = (hcnt == HMAX);
   assign line_end = ce & at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt      <= line_reload(RM_50HZ);
         line_mode <= RM_50HZ;
         mono_q    <= 1'b0;
      end else if (ce) begin
         if (at_top) begin
            hcnt      <= line_reload(mode_in);
            line_mode <= mode_in;
            mono_q    <= mono_in;
         end else begin
            hcnt <= hcnt + HW'(1);
         end
      end
   end

   assign line_start = ce & (hcnt == line_reload(line_mode));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && hcnt != HMAX) |=> (hcnt == $past(hcnt) + HW'(1)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce) |=> $stable(hcnt));

   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && hcnt == HMAX) |=> (hcnt == HW'(0) || hcnt == HW'(1) || hcnt == HW'(72)));

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
   import raster_pkg::*;
#(
   parameter int unsigned VW             = 9,
   parameter int unsigned V_START_60     = 249,
   parameter int unsigned V_START_50     = 199,
   parameter int unsigned V_START_70     = 11,
   parameter int unsigned VS_COLOR_LINES = 3,
   parameter int unsigned VS_MONO_LINES  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [1:0]    mode_in,
   input  logic          mono_q,
   output logic [VW-1:0] vcnt,
   output logic          vsync
);
   localparam logic [VW-1:0] VMAX     = {VW{1'b1}};
   localparam logic [VW-1:0] TH_COLOR = VW'((2**VW) - VS_COLOR_LINES);
   localparam logic [VW-1:0] TH_MONO  = VW'((2**VW) - VS_MONO_LINES);

   logic [VW-1:0] frame_start;

   always_comb begin
      unique case (mode_in)
         RM_60HZ: frame_start = VW'(V_START_60);
         RM_50HZ: frame_start = VW'(V_START_50);
         default: frame_start = VW'(V_START_70);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          vcnt <= VW'(V_START_50);
      else if (adv) begin
         if (vcnt == VMAX) vcnt <= frame_start;
         else              vcnt <= vcnt + VW'(1);
      end
   end

   generate
      if (VS_COLOR_LINES == VS_MONO_LINES) begin : g_one_len
         assign vsync = (vcnt >= TH_COLOR);
      end else begin : g_two_len
         assign vsync = mono_q ? (vcnt >= TH_MONO) : (vcnt >= TH_COLOR);
      end
   endgenerate

   assert_vhold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv) |=> $stable(vcnt));

endmodule

// File: rtl/raster_hwin.sv
module raster_hwin #(
   parameter int unsigned HW          = 7,
   parameter int unsigned HBLANK_FROM = 112,
   parameter int unsigned HSYNC_FROM  = 120
) (
   input  logic [HW-1:0] hcnt,
   input  logic          mono_q,
   output logic          hblank,
   output logic          hsync
);
   localparam logic [HW-1:0] HB_TH = HW'(HBLANK_FROM);
   localparam logic [HW-1:0] HS_TH = HW'(HSYNC_FROM);

   assign hblank = mono_q | (hcnt >= HB_TH);
   assign hsync  = (hcnt >= HS_TH);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import raster_pkg::*;
#(
   parameter int unsigned HW             = LINE_W,
   parameter int unsigned VW             = 9,
   parameter int unsigned V_START_60     = 249,
   parameter int unsigned V_START_50     = 199,
   parameter int unsigned V_START_70     = 11,
   parameter int unsigned VS_COLOR_LINES = 3,
   parameter int unsigned VS_MONO_LINES  = 1,
   parameter int unsigned HBLANK_FROM    = 112,
   parameter int unsigned HSYNC_FROM     = 120
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_ce,
   input  logic [1:0]    mode,
   input  logic          mono,
   output logic          line_end,
   output logic          line_start,
   output logic          hsync,
   output logic          hblank,
   output logic          vsync,
   output logic [HW-1:0] hcnt,
   output logic [VW-1:0] vcnt
);
   localparam int unsigned VLINES = 2**VW;
   localparam logic [VW-1:0] VS_EARLIEST = VW'(VLINES - VS_COLOR_LINES);

   generate
      if (HW != 7) begin : g_bad_hw
         $error("raster_timing_gen: horizontal counter must be 7 bits");
      end
      if (HBLANK_FROM >= 2**HW || HSYNC_FROM >= 2**HW) begin : g_bad_hwin
         $error("raster_timing_gen: blank/sync start outside the line");
      end
      if (VS_COLOR_LINES < VS_MONO_LINES || VS_MONO_LINES == 0) begin : g_bad_vs
         $error("raster_timing_gen: sync line counts inconsistent");
      end
      if (V_START_60 + VS_COLOR_LINES >= VLINES || V_START_50 + VS_COLOR_LINES >= VLINES ||
          V_START_70 + VS_COLOR_LINES >= VLINES) begin : g_bad_vstart
         $error("raster_timing_gen: frame start leaves no room for vsync");
      end
   endgenerate

   logic mono_q;

   raster_hcount #(.HW(HW)) u_hcount (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce         (cnt_ce),
      .mode_in    (mode),
      .mono_in    (mono),
      .hcnt       (hcnt),
      .mono_q     (mono_q),
      .line_end   (line_end),
      .line_start (line_start)
   );

   raster_vcount #(
      .VW             (VW),
      .V_START_60     (V_START_60),
      .V_START_50     (V_START_50),
      .V_START_70     (V_START_70),
      .VS_COLOR_LINES (VS_COLOR_LINES),
      .VS_MONO_LINES  (VS_MONO_LINES)
   ) u_vcount (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (line_end),
      .mode_in (mode),
      .mono_q  (mono_q),
      .vcnt    (vcnt),
      .vsync   (vsync)
   );

   raster_hwin #(
      .HW          (HW),
      .HBLANK_FROM (HBLANK_FROM),
      .HSYNC_FROM  (HSYNC_FROM)
   ) u_hwin (
      .hcnt   (hcnt),
      .mono_q (mono_q),
      .hblank (hblank),
      .hsync  (hsync)
   );

   assert_vadv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      line_end |=> (vcnt != $past(vcnt)));

   assert_vsync_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |-> (vcnt >= VS_EARLIEST));

   assert_blank_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hblank) |-> $past(line_end));

endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n, ce, mono;
   logic [1:0] mode;
   logic       line_end, line_start, hsync, hblank, vsync;
   logic [6:0] hcnt;
   logic [8:0] vcnt;

   int errs   = 0;
   int checks = 0;

   raster_timing_gen #(
      .V_START_60 (504),
      .V_START_50 (500),
      .V_START_70 (506)
   ) u_raster_timing_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_ce     (ce),
      .mode       (mode),
      .mono       (mono),
      .line_end   (line_end),
      .line_start (line_start),
      .hsync      (hsync),
      .hblank     (hblank),
      .vsync      (vsync),
      .hcnt       (hcnt),
      .vcnt       (vcnt)
   );

   typedef struct packed {
      logic [1:0] m;
      logic       mo;
      logic [7:0] len;
      logic [9:0] fl;
      logic [3:0] vs;
   } vec_t;

   // mode, mono, line steps, frame lines (shortened starts), vsync lines
   localparam logic [24:0] VECS [5] = '{
      {2'b00, 1'b0, 8'd127, 10'd8,  4'd3},
      {2'b01, 1'b0, 8'd128, 10'd12, 4'd3},
      {2'b10, 1'b1, 8'd56,  10'd6,  4'd1},
      {2'b11, 1'b1, 8'd56,  10'd6,  4'd1},
      {2'b01, 1'b1, 8'd128, 10'd12, 4'd1}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(negedge clk);
      #1;
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      #(8 * 190000);
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int vc;
      int exp_v;
      bit prev;
      rst_n = 1'b0; ce = 1'b0; mode = 2'b01; mono = 1'b0;
      tick(); tick();
      // R1 reset state
      chk(hcnt == 7'd0, "R1 hcnt", hcnt, 0);
      chk(vcnt == 9'd500, "R1 vcnt", vcnt, 500);
      chk(!vsync && !hsync && !hblank, "R1 sync outputs", {vsync, hsync, hblank}, 0);
      rst_n = 1'b1;
      // R2 hold with enable low
      for (int i = 0; i < 4; i++) tick();
      chk(hcnt == 7'd0 && vcnt == 9'd500, "R2 hold", hcnt, 0);
      chk(!line_end, "R2 no line end when idle", line_end, 0);
      ce = 1'b1;
      #1;
      chk(line_start, "R5 line_start at reload value", line_start, 1);
      tick();
      chk(hcnt == 7'd1, "R2 step", hcnt, 1);

      // table walk
      for (int k = 0; k < 5; k++) begin
         vec_t v;
         int n, bad_hb, bad_hs, fl, vs;
         v = vec_t'(VECS[k]);
         mode = v.m; mono = v.mo;
         while (!line_end) tick();
         n = 0; bad_hb = 0; bad_hs = 0;
         do begin
            tick();
            n++;
            if (hblank != (v.mo ? 1'b1 : (hcnt >= 7'd112))) bad_hb++;
            if (hsync != (hcnt >= 7'd120)) bad_hs++;
         end while (!line_end);
         chk(n == int'(v.len), "R4 line length", n, int'(v.len));
         chk(bad_hb == 0, "R9 hblank window", bad_hb, 0);
         chk(bad_hs == 0, "R10 hsync window", bad_hs, 0);
         prev = vsync;
         forever begin
            tick();
            if (prev && !vsync) break;
            prev = vsync;
         end
         fl = 0; vs = 0; prev = vsync;
         forever begin
            tick();
            if (prev && !vsync) break;
            if (line_end) begin
               fl++;
               if (vsync) vs++;
            end
            prev = vsync;
         end
         chk(fl == int'(v.fl), "R7 frame lines", fl, int'(v.fl));
         chk(vs == int'(v.vs), "R8 vsync lines", vs, int'(v.vs));
      end

      // R3 / R5 reload sequence in mode 10
      mode = 2'b10; mono = 1'b0;
      while (!line_end) tick();
      while (hcnt != 7'd126) tick();
      vc = int'(vcnt);
      tick();
      chk(hcnt == 7'd127, "R3 count before reload", hcnt, 127);
      chk(line_end, "R5 line_end at 127", line_end, 1);
      chk(int'(vcnt) == vc, "R5 vcnt steady mid-line", vcnt, vc);
      tick();
      exp_v = (vc == 511) ? 506 : vc + 1;
      chk(hcnt == 7'd72, "R3 reload value mode 10", hcnt, 72);
      chk(int'(vcnt) == exp_v, "R5 vcnt advance on line end", vcnt, exp_v);
      chk(line_start, "R5 line_start mode 10", line_start, 1);

      // R6 mid-line change
      while (hcnt != 7'd80) tick();
      mode = 2'b01; mono = 1'b1;
      tick();
      chk(hblank == 1'b0, "R6 mono deferred", hblank, 0);
      chk(hcnt == 7'd81, "R6 line continues", hcnt, 81);
      while (!line_end) tick();
      tick();
      chk(hcnt == 7'd0, "R6 new mode reload", hcnt, 0);
      chk(hblank == 1'b1, "R9 mono blank", hblank, 1);
      chk(line_start, "R6 line mode captured", line_start, 1);

      // R1 reset in mid-run
      while (hcnt != 7'd40) tick();
      rst_n = 1'b0;
      #1;
      chk(hcnt == 7'd0 && vcnt == 9'd500, "R1 async reset counts", hcnt, 0);
      chk(!vsync && !hsync && !hblank, "R1 async reset outputs", {vsync, hsync, hblank}, 0);
      tick();
      rst_n = 1'b1;
      tick();
      finish_run();
   end

endmodule